// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control unit of a multicycle processor datapath. It is a Moore state machine that walks the datapath through a series of one-cycle steps. Every instruction starts with the same two steps: fetch, then decode with register read. After that the path splits by instruction class. Load, store, register-register ALU operations, branch-if-equal and jump each finish after a different number of cycles, and then return to fetch.

The only data input is the 6-bit opcode field of the instruction register. Every control output depends only on the current step. The next step depends on the current step and, in the decode and address-compute steps, on the opcode. Decoding the function field for the ALU is done elsewhere. The current step is also brought out as a 4-bit code, so the datapath and the test environment can observe the sequence.

Top module: `mc_ctl_fsm`

## Requirements
- R1: While rst_n is low at a rising clock edge, the step becomes fetch (code 0) after that edge. The reset is synchronous and active low, and it also aborts an instruction that is in progress.
- R2: In fetch (code 0), the following outputs are set: mem_rd=1, ir_ld=1, pc_wr=1, addr_sel_data=0 (PC), alu_a_sel=0 (PC), alu_b_sel=01 (constant 4) and alu_ctl=00 (add). All other outputs are 0. The next step is always decode (code 1).
- R3: In decode (code 1), alu_a_sel=0, alu_b_sel=11 (shifted sign-extended immediate) and alu_ctl=00. All enables are 0. The next step is selected by opcode as follows:
  - 100011 (load) or 101011 (store): address compute (code 2)
  - 000000 (register-register): ALU execute (code 6)
  - 000100 (branch-if-equal): branch (code 8)
  - 000010 (jump): jump (code 9)
- R4: A load follows the steps 0,1,2,3,4,0.
  - Address compute (2): alu_a_sel=1 (A), alu_b_sel=10 (sign-extended immediate), alu_ctl=00.
  - Memory read (3): mem_rd=1, addr_sel_data=1 (ALU result register).
  - Write-back (4): rf_wr=1, wb_from_mem=1, rf_dst_rd=0.
- R5: A store follows the steps 0,1,2,5,0. In step 5, mem_wr=1 and addr_sel_data=1. In step 2, any opcode other than load leads to step 5.
- R6: A register-register instruction follows the steps 0,1,6,7,0.
  - Step 6: alu_a_sel=1, alu_b_sel=00 (B), alu_ctl=10 (function field).
  - Step 7: rf_wr=1, rf_dst_rd=1, wb_from_mem=0.
- R7: Branch-if-equal follows the steps 0,1,8,0. In step 8, alu_a_sel=1, alu_b_sel=00, alu_ctl=01 (subtract), pc_wr_if_zero=1 and pc_src=01 (ALU result register).
- R8: Jump follows the steps 0,1,9,0. In step 9, pc_wr=1 and pc_src=10 (jump target). All other outputs are 0.
- R9: In decode, an opcode outside the five listed values leads back to fetch. An unused step code (10 to 15) also leads to fetch, with all outputs 0.
- R10: Each enable is set only in the steps that need it:
  - mem_wr: only in step 5
  - rf_wr: only in steps 4 and 7
  - pc_wr: only in steps 0 and 9
  - ir_ld: only in step 0
  - pc_wr_if_zero: only in step 8
  - mem_rd and mem_wr are never both 1.
- R11: The opcode has no effect on the step sequence or on the outputs in any step other than decode and address compute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| opcode | input | 6 | Opcode field of the instruction register |
| step | output | 4 | Current step code |
| pc_wr | output | 1 | Unconditional PC write enable |
| pc_wr_if_zero | output | 1 | PC write enable, qualified by ALU zero |
| addr_sel_data | output | 1 | Memory address select: 0 PC, 1 ALU result register |
| mem_rd | output | 1 | Memory read enable |
| mem_wr | output | 1 | Memory write enable |
| ir_ld | output | 1 | Instruction register load |
| wb_from_mem | output | 1 | Register write data select: 1 memory data, 0 ALU result register |
| pc_src | output | 2 | PC source: 00 ALU, 01 ALU result register, 10 jump target |
| alu_ctl | output | 2 | ALU operation: 00 add, 01 subtract, 10 function field |
| alu_a_sel | output | 1 | ALU A operand: 0 PC, 1 register A |
| alu_b_sel | output | 2 | ALU B operand: 00 B, 01 four, 10 immediate, 11 shifted immediate |
| rf_wr | output | 1 | Register file write enable |
| rf_dst_rd | output | 1 | Destination register select: 1 rd field, 0 rt field |

## Verification
An illegal or mistaken step register shows at the ports in the same cycle. The step code is wrong, and the control outputs no longer match that step: for example, a memory write or register write lands outside its step. A wrong next-step decision becomes visible one clock edge later. The instruction then lasts the wrong number of cycles, or its third step is the wrong one. The bench therefore compares the step code and every control output in every cycle of every instruction class. It also varies the opcode in the steps where the opcode must be ignored.

// File: rtl/mc_ctl_fsm_pkg.sv
`timescale 1ns/1ps
// Package: shared widths, opcode values, step codes and the control word
// of the multicycle control sequencer. Assumes a 6-bit opcode field.
package mc_ctl_fsm_pkg;

    localparam int OP_W    = 6;
    localparam int STEP_W  = 4;
    localparam int SEL2_W  = 2;

    localparam logic [OP_W-1:0] OPC_RREG  = 6'b000000;
    localparam logic [OP_W-1:0] OPC_LOAD  = 6'b100011;
    localparam logic [OP_W-1:0] OPC_STORE = 6'b101011;
    localparam logic [OP_W-1:0] OPC_BEQ   = 6'b000100;
    localparam logic [OP_W-1:0] OPC_JUMP  = 6'b000010;

    typedef enum logic [STEP_W-1:0] {
        ST_FETCH     = 4'd0,
        ST_DECODE    = 4'd1,
        ST_ADDR      = 4'd2,
        ST_LD_READ   = 4'd3,
        ST_LD_WB     = 4'd4,
        ST_ST_WRITE  = 4'd5,
        ST_ALU_EXEC  = 4'd6,
        ST_ALU_WB    = 4'd7,
        ST_BRANCH    = 4'd8,
        ST_JUMP      = 4'd9
    } step_e;

    // Operand / source select encodings
    localparam logic [SEL2_W-1:0] BSEL_REG   = 2'b00;
    localparam logic [SEL2_W-1:0] BSEL_FOUR  = 2'b01;
    localparam logic [SEL2_W-1:0] BSEL_IMM   = 2'b10;
    localparam logic [SEL2_W-1:0] BSEL_SHIMM = 2'b11;

    localparam logic [SEL2_W-1:0] ALU_ADD   = 2'b00;
    localparam logic [SEL2_W-1:0] ALU_SUB   = 2'b01;
    localparam logic [SEL2_W-1:0] ALU_FUNCT = 2'b10;

    localparam logic [SEL2_W-1:0] PCS_ALU    = 2'b00;
    localparam logic [SEL2_W-1:0] PCS_ALUREG = 2'b01;
    localparam logic [SEL2_W-1:0] PCS_JUMP   = 2'b10;

    typedef struct packed {
        logic              pc_wr;
        logic              pc_wr_if_zero;
        logic              addr_sel_data;
        logic              mem_rd;
        logic              mem_wr;
        logic              ir_ld;
        logic              wb_from_mem;
        logic [SEL2_W-1:0] pc_src;
        logic [SEL2_W-1:0] alu_ctl;
        logic              alu_a_sel;
        logic [SEL2_W-1:0] alu_b_sel;
        logic              rf_wr;
        logic              rf_dst_rd;
    } ctl_t;

endpackage

// File: rtl/mc_ctl_next_step.sv
`timescale 1ns/1ps
// Module: next-step logic. Purely combinational. Uses the opcode only in
// decode and address compute; any unused step code falls back to fetch.
module mc_ctl_next_step
    import mc_ctl_fsm_pkg::*;
(
    input  step_e           cur,
    input  logic [OP_W-1:0] opcode,
    output step_e           nxt
);

    // Choose the following step from the current step and the opcode
    always_comb begin
        nxt = ST_FETCH;
        case (cur)
            ST_FETCH:  nxt = ST_DECODE;
            ST_DECODE: begin
                case (opcode)
                    OPC_LOAD, OPC_STORE: nxt = ST_ADDR;
                    OPC_RREG:            nxt = ST_ALU_EXEC;
                    OPC_BEQ:             nxt = ST_BRANCH;
                    OPC_JUMP:            nxt = ST_JUMP;
                    default:             nxt = ST_FETCH;
                endcase
            end
            ST_ADDR:     nxt = (opcode == OPC_LOAD) ? ST_LD_READ : ST_ST_WRITE;
            ST_LD_READ:  nxt = ST_LD_WB;
            ST_ALU_EXEC: nxt = ST_ALU_WB;
            default:     nxt = ST_FETCH;
        endcase
    end

endmodule

// File: rtl/mc_ctl_step_reg.sv
`timescale 1ns/1ps
// Module: step register. Assumes reset is synchronous and active low;
// reset forces fetch.
module mc_ctl_step_reg
    import mc_ctl_fsm_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  step_e nxt,
    output step_e cur
);

    // Hold the current step, loading fetch on reset
    always_ff @(posedge clk) begin
        if (!rst_n) cur <= ST_FETCH;
        else        cur <= nxt;
    end

endmodule

// File: rtl/mc_ctl_out_decode.sv
`timescale 1ns/1ps
// Module: Moore output decode. Maps a step to its control word. Enables
// default to 0; selects that are don't-care in a step are driven to 0.
module mc_ctl_out_decode
    import mc_ctl_fsm_pkg::*;
(
    input  step_e cur,
    output ctl_t  ctl
);

    // Produce the control word for the current step
    always_comb begin
        ctl = '0;
        case (cur)
            ST_FETCH: begin
                ctl.mem_rd    = 1'b1;
                ctl.ir_ld     = 1'b1;
                ctl.pc_wr     = 1'b1;
                ctl.alu_b_sel = BSEL_FOUR;
                ctl.alu_ctl   = ALU_ADD;
                ctl.pc_src    = PCS_ALU;
            end
            ST_DECODE: begin
                ctl.alu_b_sel = BSEL_SHIMM;
                ctl.alu_ctl   = ALU_ADD;
            end
            ST_ADDR: begin
                ctl.alu_a_sel = 1'b1;
                ctl.alu_b_sel = BSEL_IMM;
                ctl.alu_ctl   = ALU_ADD;
            end
            ST_LD_READ: begin
                ctl.mem_rd        = 1'b1;
                ctl.addr_sel_data = 1'b1;
            end
            ST_LD_WB: begin
                ctl.rf_wr       = 1'b1;
                ctl.wb_from_mem = 1'b1;
                ctl.rf_dst_rd   = 1'b0;
            end
            ST_ST_WRITE: begin
                ctl.mem_wr        = 1'b1;
                ctl.addr_sel_data = 1'b1;
            end
            ST_ALU_EXEC: begin
                ctl.alu_a_sel = 1'b1;
                ctl.alu_b_sel = BSEL_REG;
                ctl.alu_ctl   = ALU_FUNCT;
            end
            ST_ALU_WB: begin
                ctl.rf_wr     = 1'b1;
                ctl.rf_dst_rd = 1'b1;
            end
            ST_BRANCH: begin
                ctl.alu_a_sel     = 1'b1;
                ctl.alu_b_sel     = BSEL_REG;
                ctl.alu_ctl       = ALU_SUB;
                ctl.pc_wr_if_zero = 1'b1;
                ctl.pc_src        = PCS_ALUREG;
            end
            ST_JUMP: begin
                ctl.pc_wr  = 1'b1;
                ctl.pc_src = PCS_JUMP;
            end
            default: ctl = '0;
        endcase
    end

endmodule

// File: rtl/mc_ctl_fsm.sv
`timescale 1ns/1ps
// Module: top of the multicycle control sequencer. Joins the step register,
// the next-step logic and the output decode, and flattens the control word
// onto ports. Assumes the opcode is stable at each rising edge.
module mc_ctl_fsm
    import mc_ctl_fsm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OP_W-1:0]   opcode,
    output logic [STEP_W-1:0] step,
    output logic              pc_wr,
    output logic              pc_wr_if_zero,
    output logic              addr_sel_data,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              ir_ld,
    output logic              wb_from_mem,
    output logic [SEL2_W-1:0] pc_src,
    output logic [SEL2_W-1:0] alu_ctl,
    output logic              alu_a_sel,
    output logic [SEL2_W-1:0] alu_b_sel,
    output logic              rf_wr,
    output logic              rf_dst_rd
);

    step_e cur_step;
    step_e nxt_step;
    ctl_t  ctl;

    mc_ctl_step_reg u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .nxt   (nxt_step),
        .cur   (cur_step)
    );

    mc_ctl_next_step u_nxt (
        .cur    (cur_step),
        .opcode (opcode),
        .nxt    (nxt_step)
    );

    mc_ctl_out_decode u_dec (
        .cur (cur_step),
        .ctl (ctl)
    );

    // Drive the output ports from the step and the control word
    always_comb begin
        step          = cur_step;
        pc_wr         = ctl.pc_wr;
        pc_wr_if_zero = ctl.pc_wr_if_zero;
        addr_sel_data = ctl.addr_sel_data;
        mem_rd        = ctl.mem_rd;
        mem_wr        = ctl.mem_wr;
        ir_ld         = ctl.ir_ld;
        wb_from_mem   = ctl.wb_from_mem;
        pc_src        = ctl.pc_src;
        alu_ctl       = ctl.alu_ctl;
        alu_a_sel     = ctl.alu_a_sel;
        alu_b_sel     = ctl.alu_b_sel;
        rf_wr         = ctl.rf_wr;
        rf_dst_rd     = ctl.rf_dst_rd;
    end

endmodule

// File: rtl/mc_ctl_fsm_chk.sv
`timescale 1ns/1ps
// Module: protocol checker for the control sequencer, bound to the top.
// Observes ports only.
module mc_ctl_fsm_chk
    import mc_ctl_fsm_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [OP_W-1:0]   opcode,
    input logic [STEP_W-1:0] step,
    input logic              pc_wr,
    input logic              pc_wr_if_zero,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic              ir_ld,
    input logic [SEL2_W-1:0] pc_src,
    input logic              rf_wr
);

    logic op_known;
    // Flag opcodes the sequencer recognises
    always_comb op_known = (opcode == OPC_RREG) || (opcode == OPC_LOAD) ||
                           (opcode == OPC_STORE) || (opcode == OPC_BEQ) ||
                           (opcode == OPC_JUMP);

    a_r1_reset_fetch: assert property (@(posedge clk)
        !rst_n |=> step == ST_FETCH);

    a_r2_fetch_then_decode: assert property (@(posedge clk) disable iff (!rst_n)
        step == ST_FETCH |=> step == ST_DECODE);

    a_r4_read_then_wb: assert property (@(posedge clk) disable iff (!rst_n)
        step == ST_LD_READ |=> step == ST_LD_WB);

    a_r5_store_returns: assert property (@(posedge clk) disable iff (!rst_n)
        step == ST_ST_WRITE |=> step == ST_FETCH);

    a_r7_branch_returns: assert property (@(posedge clk) disable iff (!rst_n)
        step == ST_BRANCH |=> step == ST_FETCH);

    a_r8_jump_pc_src: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_wr && step != ST_FETCH) |-> pc_src == PCS_JUMP);

    a_r9_unknown_to_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (step == ST_DECODE && !op_known) |=> step == ST_FETCH);

    a_r10_mem_wr_state: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> step == ST_ST_WRITE);

    a_r10_rf_wr_state: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr |-> (step == ST_LD_WB || step == ST_ALU_WB));

    a_r10_ir_ld_state: assert property (@(posedge clk) disable iff (!rst_n)
        ir_ld |-> step == ST_FETCH);

    a_r10_cond_wr_state: assert property (@(posedge clk) disable iff (!rst_n)
        pc_wr_if_zero |-> step == ST_BRANCH);

    a_r10_mem_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_rd, mem_wr}));

endmodule

bind mc_ctl_fsm mc_ctl_fsm_chk chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .opcode        (opcode),
    .step          (step),
    .pc_wr         (pc_wr),
    .pc_wr_if_zero (pc_wr_if_zero),
    .mem_rd        (mem_rd),
    .mem_wr        (mem_wr),
    .ir_ld         (ir_ld),
    .pc_src        (pc_src),
    .rf_wr         (rf_wr)
);

// File: tb/mc_ctl_fsm_tb_top.sv
`timescale 1ns/1ps
// Bench: scoreboard for the control sequencer. The driver pushes one
// expected item per cycle, and the monitor pops and compares at each
// falling edge.
module mc_ctl_fsm_tb_top;

    typedef struct {
        logic [3:0]  step;
        logic [15:0] ctl;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  opcode = 6'b0;
    logic [3:0]  step;
    logic        pc_wr, pc_wr_if_zero, addr_sel_data, mem_rd, mem_wr, ir_ld;
    logic        wb_from_mem, alu_a_sel, rf_wr, rf_dst_rd;
    logic [1:0]  pc_src, alu_ctl, alu_b_sel;

    exp_t        sb_q[$];
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    mc_ctl_fsm dut_i (
        .clk(clk), .rst_n(rst_n), .opcode(opcode), .step(step),
        .pc_wr(pc_wr), .pc_wr_if_zero(pc_wr_if_zero),
        .addr_sel_data(addr_sel_data), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .ir_ld(ir_ld), .wb_from_mem(wb_from_mem), .pc_src(pc_src),
        .alu_ctl(alu_ctl), .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel),
        .rf_wr(rf_wr), .rf_dst_rd(rf_dst_rd)
    );

    // Control word order: pc_wr, pc_wr_if_zero, addr_sel_data, mem_rd,
    // mem_wr, ir_ld, wb_from_mem, pc_src[2], alu_ctl[2], alu_a_sel,
    // alu_b_sel[2], rf_wr, rf_dst_rd.
    function automatic logic [15:0] exp_ctl(input logic [3:0] s);
        case (s)
            4'd0: return {1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,2'b00,2'b00,1'b0,2'b01,1'b0,1'b0};
            4'd1: return {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,2'b00,1'b0,2'b11,1'b0,1'b0};
            4'd2: return {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,2'b00,1'b1,2'b10,1'b0,1'b0};
            4'd3: return {1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,2'b00,2'b00,1'b0,2'b00,1'b0,1'b0};
            4'd4: return {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'b00,2'b00,1'b0,2'b00,1'b1,1'b0};
            4'd5: return {1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,2'b00,2'b00,1'b0,2'b00,1'b0,1'b0};
            4'd6: return {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,2'b10,1'b1,2'b00,1'b0,1'b0};
            4'd7: return {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,2'b00,1'b0,2'b00,1'b1,1'b1};
            4'd8: return {1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,2'b01,2'b01,1'b1,2'b00,1'b0,1'b0};
            4'd9: return {1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b10,2'b00,1'b0,2'b00,1'b0,1'b0};
            default: return 16'h0;
        endcase
    endfunction

    // Compare one observation against one expected item
    task automatic compare(input exp_t e);
        logic [15:0] act;
        act = {pc_wr, pc_wr_if_zero, addr_sel_data, mem_rd, mem_wr, ir_ld,
               wb_from_mem, pc_src, alu_ctl, alu_a_sel, alu_b_sel, rf_wr, rf_dst_rd};
        n_chk++;
        if (step !== e.step || act !== e.ctl) begin
            n_fail++;
            $display("FAIL %s: step=%0d ctl=%h expected step=%0d ctl=%h",
                     e.req, step, act, e.step, e.ctl);
        end
    endtask

    // Monitor: pop and compare one item per cycle at the falling edge
    always @(negedge clk) begin
        if (sb_q.size() > 0) compare(sb_q.pop_front());
    end

    // Driver: called in the fetch cycle, just after the rising edge. It
    // pushes the expected path and applies the opcode. The true opcode is
    // applied in decode and address compute, and noise elsewhere (R11).
    task automatic run_instr(input logic [5:0] op, input string req);
        logic [3:0] path[6];
        int         n;
        path[0] = 4'd0; path[1] = 4'd1; n = 2;
        case (op)
            6'b100011: begin path[2]=4'd2; path[3]=4'd3; path[4]=4'd4; n=5; end
            6'b101011: begin path[2]=4'd2; path[3]=4'd5; n=4; end
            6'b000000: begin path[2]=4'd6; path[3]=4'd7; n=4; end
            6'b000100: begin path[2]=4'd8; n=3; end
            6'b000010: begin path[2]=4'd9; n=3; end
            default:   n = 2;
        endcase
        for (int i = 0; i < n; i++) begin
            exp_t e;
            e.step = path[i];
            e.ctl  = exp_ctl(path[i]);
            e.req  = req;
            sb_q.push_back(e);
        end
        for (int i = 0; i < n; i++) begin
            if (path[i] == 4'd1 || path[i] == 4'd2) opcode = op;
            else opcode = (op == 6'b100011) ? 6'b101011 : 6'b100011;
            @(posedge clk); #2;
        end
    endtask

    // Watchdog: an expired run counts as a failure and still reports
    initial begin
        #(8 * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    // Main stimulus sequence
    initial begin
        exp_t e;
        rst_n  = 1'b0;
        opcode = 6'b000100;
        repeat (3) @(posedge clk);
        #2;
        e.step = 4'd0; e.ctl = exp_ctl(4'd0); e.req = "R1";
        @(negedge clk); compare(e);
        @(posedge clk); #2;
        rst_n = 1'b1;

        run_instr(6'b100011, "R4");
        run_instr(6'b101011, "R5");
        run_instr(6'b000000, "R6");
        run_instr(6'b000100, "R7");
        run_instr(6'b000010, "R8");
        run_instr(6'b111111, "R9");
        run_instr(6'b000001, "R9");
        run_instr(6'b000000, "R11");
        run_instr(6'b100011, "R10");
        run_instr(6'b000000, "R2/R3");

        // Reset during memory read aborts the load (R1)
        for (int i = 0; i < 4; i++) begin
            e.step = (i == 0) ? 4'd0 : (i == 1) ? 4'd1 : (i == 2) ? 4'd2 : 4'd3;
            e.ctl  = exp_ctl(e.step);
            e.req  = "R1";
            sb_q.push_back(e);
        end
        opcode = 6'b000000; @(posedge clk); #2;
        opcode = 6'b100011; @(posedge clk); #2;
        @(posedge clk); #2;
        rst_n = 1'b0;
        @(posedge clk); #2;
        rst_n = 1'b1;
        run_instr(6'b000010, "R1");
        run_instr(6'b000100, "R7");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule